// File: doc/BRIEF.md
# Multi-Mode Display Bus Writer

This block sits between a requester inside the chip and a graphic display controller. It accepts one byte transfer at a time. Each transfer is marked as a command or as display data, and may be a write or a read. The block sequences the display bus in one of three modes: a write-only serial link with a clock and a data line, a parallel bus of the 6800 style with a read/write line and an enable strobe, or a parallel bus of the 8080 style with separate active-low write and read strobes. The mode is taken from two select inputs, which are sampled at the moment a request is accepted.

A transfer goes through fixed phases. A parallel read first has a turnaround phase with the data bus released. Every transfer then has a setup phase in which data/command and the strobes settle. Next comes the chip-select-low window: the strobe pulse on a parallel bus, or the bit shift on the serial link. A hold phase follows. Each phase lasts a parameterised number of clocks, so the display's setup, pulse-width and hold figures can be met. The requester sees `busy` for the whole transfer and a single-cycle `done` when chip select returns high. A read captures the parallel bus into `rd_data`. A read request in serial mode is refused with a one-cycle `rd_err`.

Top module: `disp_bus_writer`

## Requirements
- R1: `sel` is sampled when a request is accepted. 2'b00 and 2'b01 select the serial mode, 2'b10 the 6800-style mode and 2'b11 the 8080-style mode.
- R2: `dc` is 0 for a command and 1 for data. It holds that value from the setup phase, before `cs_n` falls, until the transfer ends. Whenever `busy` is low, `dc` is 1.
- R3: In serial mode `cs_n` is low for exactly 16*SPI_HALF clocks. `sclk` is high whenever `cs_n` is high. Each bit has a low half and then a high half of SPI_HALF clocks each. `mosi` carries the byte MSB first and is valid at every rising edge of `sclk`.
- R4: A read request in serial mode is refused. `rd_err` is high for exactly one cycle, `busy` stays low, `cs_n` stays high and `done` does not pulse.
- R5: A 6800-style write holds `rw_wr_n`=0, `en_rd_n`=1 and `db_oe`=1, with `db_o` equal to the byte, while `cs_n` is low. After the transfer both lines rest at `rw_wr_n`=1 and `en_rd_n`=0.
- R6: An 8080-style write holds `rw_wr_n`=0, `en_rd_n`=1 and `db_oe`=1 while `cs_n` is low. After the transfer both strobes rest high.
- R7: A 6800-style read holds `rw_wr_n`=1 and `en_rd_n`=1 with `db_oe`=0 while `cs_n` is low. `rd_data` takes `db_i` as sampled in the last cycle that `cs_n` is low.
- R8: An 8080-style read holds `en_rd_n`=0 and `rw_wr_n`=1 with `db_oe`=0 while `cs_n` is low. `rd_data` takes `db_i` from the last cycle that `cs_n` is low.
- R9: For a parallel read, `db_oe` is 0 throughout the transfer. A turnaround phase of T_SETUP clocks runs with both strobes at rest before any strobe is asserted.
- R10: On a parallel bus, `cs_n` falls T_SETUP clocks after acceptance (plus T_SETUP more for a read). It stays low for T_PULSE clocks and is followed by T_HOLD hold clocks.
- R11: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the hold phase ends, and requests made while `busy` is high are ignored. `done` is high for one cycle, the first cycle in which `cs_n` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Bus mode select, sampled on acceptance |
| req_valid | input | 1 | Transfer request |
| req_is_data | input | 1 | 1 = data byte, 0 = command byte |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_byte | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | One-cycle pulse on a refused serial read |
| rd_data | output | 8 | Byte captured by the last read |
| cs_n | output | 1 | Display chip select, active low |
| dc | output | 1 | Data/command select |
| rw_wr_n | output | 1 | Read/write line (6800) or write strobe (8080) |
| en_rd_n | output | 1 | Enable (6800) or read strobe (8080) |
| db_o | output | 8 | Parallel data out |
| db_oe | output | 1 | Parallel data output enable |
| db_i | input | 8 | Parallel data in |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |

## Verification
With the defaults (T_SETUP=2, T_PULSE=3, T_HOLD=2, SPI_HALF=2), a write accepted at one clock edge drops `cs_n` in cycle 3 after that edge and raises `done` in cycle 6. `busy` falls in cycle 8. A parallel read shifts all of these by two cycles. A serial write keeps `cs_n` low for 32 cycles, puts `done` in cycle 35 and ends in cycle 37. A refused read shows `rd_err` in cycle 1. The bench samples every output at the falling clock edge and numbers each sample by the rising edges since the request was taken. Each result is then compared against that cycle number and not against any event in the design.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;

    typedef enum logic [1:0] {
        BUS_SER = 2'd0,
        BUS_M68 = 2'd1,
        BUS_I80 = 2'd2
    } bus_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_SHIFT  = 3'd4,
        PH_HOLD   = 3'd5
    } phase_e;

    typedef struct packed {
        bus_mode_e  mode;
        logic       is_data;
        logic       is_read;
        logic [7:0] payload;
    } xfer_t;

    // upper select bit low -> serial; both high -> 8080; upper only -> 6800
    function automatic bus_mode_e decode_mode(input logic [1:0] s);
        if (!s[1])     return BUS_SER;
        else if (s[0]) return BUS_I80;
        else           return BUS_M68;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dbw_phase_timer.sv
module dbw_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] len,
    output logic          first,
    output logic          last
);
    logic [CW-1:0] cnt;

    assign first = (cnt == '0);
    assign last  = (cnt == len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (!last)     cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/dbw_spi_shifter.sv
module dbw_spi_shifter #(
    parameter int SPI_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       sclk,
    output logic       mosi,
    output logic       fin
);
    localparam int HW = (SPI_HALF > 1) ? $clog2(SPI_HALF) : 1;

    logic          active;
    logic          hi_half;
    logic [HW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    sreg;
    logic          half_end;

    assign half_end = (div_cnt == HW'(SPI_HALF - 1));
    assign sclk     = !(active && !hi_half);
    assign mosi     = active ? sreg[7] : 1'b0;
    assign fin      = active && hi_half && half_end && (bit_cnt == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            hi_half <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sreg    <= '0;
        end else if (start) begin
            active  <= 1'b1;
            hi_half <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sreg    <= tx_byte;
        end else if (active) begin
            if (half_end) begin
                div_cnt <= '0;
                hi_half <= !hi_half;
                if (hi_half) begin
                    sreg    <= {sreg[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) active <= 1'b0;
                end
            end else begin
                div_cnt <= div_cnt + HW'(1);
            end
        end
    end

    // R3
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> sclk);
endmodule

// File: rtl/disp_bus_writer.sv
module disp_bus_writer
    import disp_bus_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_PULSE  = 3,
    parameter int T_HOLD   = 2,
    parameter int SPI_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    input  logic       req_valid,
    input  logic       req_is_data,
    input  logic       req_rd,
    input  logic [7:0] req_byte,
    output logic       busy,
    output logic       done,
    output logic       rd_err,
    output logic [7:0] rd_data,
    output logic       cs_n,
    output logic       dc,
    output logic       rw_wr_n,
    output logic       en_rd_n,
    output logic [7:0] db_o,
    output logic       db_oe,
    input  logic [7:0] db_i,
    output logic       sclk,
    output logic       mosi
);
    localparam int TMAX = max3(T_SETUP, T_PULSE, T_HOLD);
    localparam int CW   = $clog2(TMAX + 1);

    phase_e        state, nxt;
    xfer_t         xq;
    bus_mode_e     req_mode;
    logic          accept, reject, restart, spi_start, spi_fin;
    logic          ph_first, ph_last, act, par;
    logic [CW-1:0] ph_len;

    assign req_mode = decode_mode(sel);
    assign accept   = (state == PH_IDLE) && req_valid && !(req_rd && req_mode == BUS_SER);
    assign reject   = (state == PH_IDLE) && req_valid && req_rd && (req_mode == BUS_SER);

    always_comb begin
        unique case (state)
            PH_TURN, PH_SETUP: ph_len = CW'(T_SETUP);
            PH_STROBE:         ph_len = CW'(T_PULSE);
            PH_HOLD:           ph_len = CW'(T_HOLD);
            default:           ph_len = CW'(1);
        endcase
    end

    always_comb begin
        nxt       = state;
        spi_start = 1'b0;
        unique case (state)
            PH_IDLE:   if (accept) nxt = req_rd ? PH_TURN : PH_SETUP;
            PH_TURN:   if (ph_last) nxt = PH_SETUP;
            PH_SETUP:  if (ph_last) begin
                           nxt       = (xq.mode == BUS_SER) ? PH_SHIFT : PH_STROBE;
                           spi_start = (xq.mode == BUS_SER);
                       end
            PH_STROBE: if (ph_last) nxt = PH_HOLD;
            PH_SHIFT:  if (spi_fin) nxt = PH_HOLD;
            PH_HOLD:   if (ph_last) nxt = PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    assign restart = (nxt != state);

    dbw_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .len(ph_len),
        .first(ph_first), .last(ph_last)
    );

    dbw_spi_shifter #(.SPI_HALF(SPI_HALF)) u_spi (
        .clk(clk), .rst(rst), .start(spi_start), .tx_byte(xq.payload),
        .sclk(sclk), .mosi(mosi), .fin(spi_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_IDLE;
            xq      <= '{mode: BUS_SER, is_data: 1'b1, is_read: 1'b0, payload: 8'h00};
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            state  <= nxt;
            rd_err <= reject;
            if (accept)
                xq <= '{mode: req_mode, is_data: req_is_data, is_read: req_rd, payload: req_byte};
            if (state == PH_STROBE && ph_last && xq.is_read)
                rd_data <= db_i;
        end
    end

    assign act     = (state == PH_SETUP) || (state == PH_STROBE) || (state == PH_HOLD);
    assign par     = (xq.mode != BUS_SER);
    assign busy    = (state != PH_IDLE);
    assign done    = (state == PH_HOLD) && ph_first;
    assign cs_n    = !((state == PH_STROBE) || (state == PH_SHIFT));
    assign dc      = (state == PH_IDLE) ? 1'b1 : xq.is_data;
    assign rw_wr_n = (act && par) ? xq.is_read : 1'b1;
    assign db_oe   = act && par && !xq.is_read;
    assign db_o    = xq.payload;

    always_comb begin
        unique case (xq.mode)
            BUS_M68: en_rd_n = act;
            BUS_I80: en_rd_n = !(act && xq.is_read);
            default: en_rd_n = 1'b0;
        endcase
    end

    // R2
    dc_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $stable(dc));
    // R2
    dc_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> dc);
    // R11
    done_cs_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !$past(cs_n)));
    // R9
    rd_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && xq.is_read) |-> (!db_oe && !$past(db_oe)));
    // R3
    sclk_cs_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);
    // R4
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (!busy && cs_n && !done));
endmodule

// File: tb/tb_disp_bus_writer.sv
module tb_disp_bus_writer;
    localparam int CLK_PERIOD = 10;
    localparam int TS = 2, TP = 3, TH = 2, SH = 2;

    logic clk = 0, rst = 1;
    logic [1:0] sel = 2'b00;
    logic req_valid = 0, req_is_data = 0, req_rd = 0;
    logic [7:0] req_byte = 0;
    logic [7:0] db_i = 8'hC3;
    logic busy, done, rd_err, cs_n, dc, rw_wr_n, en_rd_n, db_oe, sclk, mosi;
    logic [7:0] rd_data, db_o;

    int n_chk = 0, n_err = 0;

    disp_bus_writer #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .SPI_HALF(SH)) dut (
        .clk(clk), .rst(rst), .sel(sel), .req_valid(req_valid), .req_is_data(req_is_data),
        .req_rd(req_rd), .req_byte(req_byte), .busy(busy), .done(done), .rd_err(rd_err),
        .rd_data(rd_data), .cs_n(cs_n), .dc(dc), .rw_wr_n(rw_wr_n), .en_rd_n(en_rd_n),
        .db_o(db_o), .db_oe(db_oe), .db_i(db_i), .sclk(sclk), .mosi(mosi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // observation record of the last transfer
    int cs_fall_k, cs_low_n, done_k, done_n, end_k, bits_n, oe_read_n, err_n, sclk_bad;
    logic dc_pre, dc_fall, rw_s, en_s, oe_s, rw_k1, en_k1, rw_end, en_end;
    logic [7:0] dbo_s, bits;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] s, input bit isd, input bit rd, input logic [7:0] b,
                        input int hold_req);
        logic dc_prev, sclk_prev;
        cs_fall_k = 0; cs_low_n = 0; done_k = 0; done_n = 0; end_k = 0; bits_n = 0;
        oe_read_n = 0; err_n = 0; sclk_bad = 0; bits = 0;
        dc_prev = dc; sclk_prev = sclk;
        sel = s; req_is_data = isd; req_rd = rd; req_byte = b; req_valid = 1;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (k >= hold_req) req_valid = 0;
            if (k == 1) begin rw_k1 = rw_wr_n; en_k1 = en_rd_n; end
            if (rd && db_oe) oe_read_n++;
            if (rd_err) err_n++;
            if (cs_n && !sclk) sclk_bad++;
            if (!cs_n) begin
                if (cs_fall_k == 0) begin
                    cs_fall_k = k; dc_pre = dc_prev; dc_fall = dc;
                    rw_s = rw_wr_n; en_s = en_rd_n; oe_s = db_oe; dbo_s = db_o;
                end
                cs_low_n++;
                if (sclk && !sclk_prev) begin bits = {bits[6:0], mosi}; bits_n++; end
            end
            if (done) begin done_n++; if (done_k == 0) done_k = k; end
            dc_prev = dc; sclk_prev = sclk;
            if (!busy) begin
                end_k = k; rw_end = rw_wr_n; en_end = en_rd_n;
                chk(dc == 1'b1, "R2", "dc at rest", dc, 1);
                break;
            end
        end
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(cs_n == 1, "R11", "reset cs_n", cs_n, 1);
        chk(busy == 0 && done == 0, "R11", "reset busy/done", {busy, done}, 0);
        chk(dc == 1, "R2", "reset dc", dc, 1);
        chk(sclk == 1 && db_oe == 0 && rd_err == 0, "R3", "reset sclk/oe/err", {sclk, db_oe, rd_err}, 3'b100);
    endtask

    task automatic t_par_write(input logic [1:0] s, input bit isd, input logic [7:0] b, input bit i80);
        string rq;
        rq = i80 ? "R6" : "R5";
        xfer(s, isd, 0, b, 1);
        chk(cs_fall_k == TS + 1, "R10", "cs fall cycle", cs_fall_k, TS + 1);
        chk(cs_low_n == TP, "R10", "cs low width", cs_low_n, TP);
        chk(done_k == TS + TP + 1 && done_n == 1, "R11", "done cycle", done_k, TS + TP + 1);
        chk(end_k == TS + TP + TH + 1, "R10", "hold end", end_k, TS + TP + TH + 1);
        chk(dc_pre == isd && dc_fall == isd, "R2", "dc before cs", {dc_pre, dc_fall}, {isd, isd});
        chk(rw_s == 0 && en_s == 1 && oe_s == 1, rq, "strobes", {rw_s, en_s, oe_s}, 3'b011);
        chk(dbo_s == b, rq, "data out", dbo_s, b);
        chk(rw_end == 1 && en_end == i80, rq, "rest strobes", {rw_end, en_end}, {1'b1, i80});
        chk(bits_n == 0, "R1", "no serial clocks", bits_n, 0);
    endtask

    task automatic t_par_read(input logic [1:0] s, input logic [7:0] v, input bit i80);
        string rq;
        rq = i80 ? "R8" : "R7";
        db_i = v;
        xfer(s, 1, 1, 8'h00, 1);
        chk(rw_k1 == 1 && en_k1 == i80, "R9", "turnaround strobes at rest", {rw_k1, en_k1}, {1'b1, i80});
        chk(oe_read_n == 0, "R9", "oe during read", oe_read_n, 0);
        chk(cs_fall_k == 2 * TS + 1, "R10", "read cs fall", cs_fall_k, 2 * TS + 1);
        chk(cs_low_n == TP, "R10", "read cs width", cs_low_n, TP);
        chk(done_k == 2 * TS + TP + 1, "R11", "read done", done_k, 2 * TS + TP + 1);
        chk(rw_s == 1 && en_s == !i80, rq, "read strobes", {rw_s, en_s}, {1'b1, !i80});
        chk(rd_data == v, rq, "rd_data", rd_data, v);
    endtask

    task automatic t_spi_write(input logic [1:0] s, input bit isd, input logic [7:0] b);
        xfer(s, isd, 0, b, 1);
        chk(cs_fall_k == TS + 1, "R3", "serial cs fall", cs_fall_k, TS + 1);
        chk(cs_low_n == 16 * SH, "R3", "serial cs width", cs_low_n, 16 * SH);
        chk(bits_n == 8 && bits == b, "R3", "shifted byte", bits, b);
        chk(sclk_bad == 0, "R3", "sclk low with cs high", sclk_bad, 0);
        chk(done_k == TS + 16 * SH + 1, "R11", "serial done", done_k, TS + 16 * SH + 1);
        chk(dc_fall == isd, "R2", "serial dc", dc_fall, isd);
        chk(rw_end == 1 && en_end == 0 && oe_s == 0, "R1", "serial mode pins", {rw_end, en_end, oe_s}, 3'b100);
    endtask

    task automatic t_spi_read_reject;
        xfer(2'b00, 1, 1, 8'h00, 1);
        chk(end_k == 1 && err_n == 1, "R4", "reject flag", err_n, 1);
        chk(cs_fall_k == 0 && done_n == 0, "R4", "no bus activity", {cs_fall_k, done_n}, 0);
        @(negedge clk);
        chk(rd_err == 0 && busy == 0, "R4", "flag one cycle", rd_err, 0);
    endtask

    task automatic t_busy_ignore;
        xfer(2'b10, 1, 0, 8'h3C, 4);
        chk(done_n == 1 && dbo_s == 8'h3C, "R11", "single transfer", done_n, 1);
        @(negedge clk);
        chk(busy == 0 && cs_n == 1, "R11", "no second transfer", busy, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_par_write(2'b10, 0, 8'hA5, 0);   // R5 6800 command write
        t_par_write(2'b11, 1, 8'h5A, 1);   // R6 8080 data write
        t_par_read(2'b10, 8'h96, 0);       // R7
        t_par_read(2'b11, 8'h4E, 1);       // R8
        t_spi_write(2'b00, 0, 8'hB2);      // R3 command
        t_spi_write(2'b01, 1, 8'h71);      // R1 01 maps to serial
        t_spi_read_reject();               // R4
        t_busy_ignore();                   // R11
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule